// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a bank of general-purpose input pins and turns selected level transitions into sticky, software-visible event bits that drive interrupt lines. Every pin has two independent sense controls, one for low-to-high and one for high-to-low transitions. A pin whose sense controls are both set reports either transition; a pin with neither set reports nothing. Inputs are brought into the clock domain by a two-stage synchroniser, and a transition is found by comparing the synchronised level with its value one cycle earlier.

Recorded events stay set until software clears them by writing ones to the event register. The low pins each own a dedicated interrupt output. The remaining pins share one summary output, which is the OR of their event bits. A simple single-cycle register port lets software write the two sense registers, read all three registers, and clear event bits.

Top module: `gpio_edge_irq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the rising-sense, falling-sense and event registers read zero, irq_direct is all zero and irq_summary is 0.
- R2: With a pin's rising-sense bit set, a 0-to-1 change on that pin sets its event bit (bit n for pin n) at address 0x8.
- R3: With a pin's falling-sense bit set, a 1-to-0 change on that pin sets its event bit.
- R4: With both sense bits set a pin records both transitions; with neither set its transitions are ignored and its event bit stays 0.
- R5: Writing to the event register at 0x8 clears each bit whose data bit is 1 and leaves bits written with 0 unchanged; writing 0x0FFFFFFF clears every event.
- R6: If a new transition and a write-1 clear hit the same event bit in the same cycle, the bit stays set.
- R7: Clearing a sense bit does not clear an event bit that is already set.
- R8: irq_direct[i] equals event bit i for pins 0 to 7.
- R9: irq_summary is 1 exactly when any event bit 8 to 27 is set.
- R10: Register map: 0x0 rising-sense, 0x4 falling-sense, 0x8 events, one bit per pin at bit n; bits 31 to 28 read as zero and any other address reads zero.
- R11: A pin change applied between clock edges appears in the event register after the third following rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_in | input | 28 | Asynchronous input pins |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_direct | output | 8 | Dedicated interrupts for pins 0 to 7 |
| irq_summary | output | 1 | OR of events for pins 8 to 27 |

## Verification
The bench sweeps every pin through all four sense settings and both transition directions, so a swapped sense register, a mis-indexed bit or a pin leaking into the wrong interrupt line shows up as a wrong event word or interrupt value. It collides a fresh transition with a write-1 clear of the same bit in the same cycle; a design giving priority to the clear would lose the event. It checks that writing zeros clears nothing, that dropping a sense bit keeps a pending event, and samples the event register one cycle before and at the point it must first be set, catching a synchroniser with the wrong number of stages.

// File: rtl/gpio_edge_pkg.sv
// Shared definitions for the GPIO edge-detect interrupt unit.
// Assumes byte addressing with word-aligned registers.
package gpio_edge_pkg;
    localparam int unsigned REG_ADDR_W = 4;

    typedef enum logic [REG_ADDR_W-1:0] {
        ADDR_RISE_SENSE = 4'h0,
        ADDR_FALL_SENSE = 4'h4,
        ADDR_EVENTS     = 4'h8
    } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherence is implied.
module gpio_in_sync #(
    parameter int WIDTH  = 28,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    // Shift the sampled inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_edge_find.sv
// Finds transitions on a synchronised level vector and qualifies them
// with per-bit rising and falling sense enables.
// Assumes level is already in the clk domain.
module gpio_edge_find #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    output logic [WIDTH-1:0] hit
);
    logic [WIDTH-1:0] prev_q;

    // Hold the level from the previous cycle for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // Qualify low-to-high and high-to-low changes by their enables.
    always_comb begin
        hit = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);
    end
endmodule

// File: rtl/gpio_event_bank.sv
// Sticky event bits: set by hits, cleared by write-one strobes.
// A hit in the same cycle as a clear of that bit keeps the bit set.
module gpio_event_bank #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_hit,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] events
);
    logic [WIDTH-1:0] clr_eff;

    // Effective clear vector, zero when no clear write is present.
    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
    end

    // Update sticky bits; setting takes priority over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) events <= '0;
        else        events <= (events & ~clr_eff) | set_hit;
    end
endmodule

// File: rtl/gpio_edge_irq.sv
// GPIO edge-detect interrupt unit top level.
// Holds the sense registers, decodes the register port, and fans the
// event bits out to dedicated and summary interrupt lines.
// Assumes one register write per strobe cycle and reads with no side effects.
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS   = 28,
    parameter int NUM_DIRECT = 8,
    parameter int DATA_W     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pins_in,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_DIRECT-1:0] irq_direct,
    output logic                  irq_summary
);
    localparam int PAD_W = DATA_W - NUM_PINS;

    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] rise_en_q;
    logic [NUM_PINS-1:0] fall_en_q;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] status_q;
    logic [NUM_PINS-1:0] rd_word;
    logic                wr_events;

    gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_in),
        .q     (sync_lvl)
    );

    gpio_edge_find #(.WIDTH(NUM_PINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (sync_lvl),
        .rise_en (rise_en_q),
        .fall_en (fall_en_q),
        .hit     (edge_hit)
    );

    gpio_event_bank #(.WIDTH(NUM_PINS)) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_hit  (edge_hit),
        .clr_we   (wr_events),
        .clr_mask (reg_wdata[NUM_PINS-1:0]),
        .events   (status_q)
    );

    // Decode a write to the event register.
    always_comb begin
        wr_events = reg_wr && (reg_addr == ADDR_EVENTS);
    end

    // Sense enable registers, written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_RISE_SENSE) rise_en_q <= reg_wdata[NUM_PINS-1:0];
            if (reg_addr == ADDR_FALL_SENSE) fall_en_q <= reg_wdata[NUM_PINS-1:0];
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        unique case (reg_addr)
            ADDR_RISE_SENSE: rd_word = rise_en_q;
            ADDR_FALL_SENSE: rd_word = fall_en_q;
            ADDR_EVENTS:     rd_word = status_q;
            default:         rd_word = '0;
        endcase
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign reg_rdata = {{PAD_W{1'b0}}, rd_word};
        end else begin : g_nopad
            assign reg_rdata = rd_word[DATA_W-1:0];
        end
    endgenerate

    // Interrupt fan-out: dedicated lines for low pins, OR for the rest.
    assign irq_direct  = status_q[NUM_DIRECT-1:0];
    assign irq_summary = |status_q[NUM_PINS-1:NUM_DIRECT];
endmodule

// File: rtl/gpio_edge_irq_chk.sv
// Property checker for gpio_edge_irq, attached by bind.
module gpio_edge_irq_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS   = 28,
    parameter int NUM_DIRECT = 8,
    parameter int DATA_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_wr,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic [NUM_PINS-1:0]   edge_hit,
    input logic [NUM_PINS-1:0]   status,
    input logic [NUM_DIRECT-1:0] irq_direct,
    input logic                  irq_summary
);
    logic [NUM_PINS-1:0] clr_req;

    always_comb begin
        clr_req = (reg_wr && reg_addr == ADDR_EVENTS) ? reg_wdata[NUM_PINS-1:0] : '0;
    end

    // R5
    event_clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status & ~$past(clr_req)) == '0));

    // R2
    event_set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & ~$past(edge_hit)) == '0));

    // R6
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(edge_hit) & ~status) == '0));

    // R8
    irq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(status) |-> ($stable(irq_direct) && $stable(irq_summary)));

    // R10
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-1:NUM_PINS] == '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
    .NUM_PINS   (NUM_PINS),
    .NUM_DIRECT (NUM_DIRECT),
    .DATA_W     (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .edge_hit    (edge_hit),
    .status      (status_q),
    .irq_direct  (irq_direct),
    .irq_summary (irq_summary)
);

// File: tb/test_gpio_edge_irq.sv
// Self-checking bench: sweeps all pins and sense modes, plus corner cases.
module test_gpio_edge_irq;
    localparam int NP = 28;
    localparam int ND = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] pins_in = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_direct;
    logic        irq_summary;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    gpio_edge_irq i_gpio_edge_irq (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_direct(irq_direct), .irq_summary(irq_summary)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=%0d exp<=150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_irqs(input string tag, input logic [27:0] ev);
        check({tag, " irq_direct"}, {24'h0, irq_direct}, {24'h0, ev[7:0]});
        check({tag, " irq_summary"}, {31'h0, irq_summary}, {31'h0, |ev[27:8]});
    endtask

    initial begin
        logic [31:0] v;
        logic [27:0] exp_ev;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_read(4'h0, v); check("R1 rise reg", v, 32'h0);
        reg_read(4'h4, v); check("R1 fall reg", v, 32'h0);
        reg_read(4'h8, v); check("R1 events", v, 32'h0);
        check_irqs("R1", 28'h0);

        // R10: register map, upper bits and unmapped address
        reg_write(4'h0, 32'hFFFF_FFFF);
        reg_read(4'h0, v); check("R10 rise readback", v, 32'h0FFF_FFFF);
        reg_write(4'h4, 32'hA5A5_A5A5);
        reg_read(4'h4, v); check("R10 fall readback", v, 32'h05A5_A5A5);
        reg_read(4'hC, v); check("R10 unmapped", v, 32'h0);

        // Sweep: every pin, every sense mode, both directions (R2 R3 R4 R8 R9)
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 4; m++) begin
                reg_write(4'h0, (m & 1) ? (32'h1 << p) : 32'h0);
                reg_write(4'h4, (m & 2) ? (32'h1 << p) : 32'h0);
                reg_write(4'h8, 32'h0FFF_FFFF);
                pins_in[p] = 1'b1;
                settle(4);
                exp_ev = (m & 1) ? (28'h1 << p) : 28'h0;
                reg_read(4'h8, v);
                check($sformatf("R2 R4 rise pin%0d mode%0d", p, m), v, {4'h0, exp_ev});
                check_irqs($sformatf("R8 R9 rise pin%0d", p), exp_ev);
                reg_write(4'h8, 32'h0FFF_FFFF);
                pins_in[p] = 1'b0;
                settle(4);
                exp_ev = (m & 2) ? (28'h1 << p) : 28'h0;
                reg_read(4'h8, v);
                check($sformatf("R3 R4 fall pin%0d mode%0d", p, m), v, {4'h0, exp_ev});
                check_irqs($sformatf("R8 R9 fall pin%0d", p), exp_ev);
            end
        end

        // R5: writing zero leaves events; writing a one clears only that bit
        reg_write(4'h0, 32'h0000_0204);
        reg_write(4'h4, 32'h0);
        reg_write(4'h8, 32'h0FFF_FFFF);
        pins_in[2] = 1'b1; pins_in[9] = 1'b1;
        settle(4);
        reg_write(4'h8, 32'h0);
        reg_read(4'h8, v); check("R5 write zero keeps", v, 32'h0000_0204);
        reg_write(4'h8, 32'h0000_0200);
        reg_read(4'h8, v); check("R5 write one clears bit", v, 32'h0000_0004);
        check_irqs("R5 R9 after clear", 28'h004);
        reg_write(4'h8, 32'h0FFF_FFFF);
        reg_read(4'h8, v); check("R5 clear all", v, 32'h0);

        // R7: dropping a sense bit keeps a pending event
        pins_in[9] = 1'b0; pins_in[2] = 1'b0;
        settle(4);
        pins_in[9] = 1'b1;
        settle(4);
        reg_write(4'h0, 32'h0);
        reg_read(4'h8, v); check("R7 event kept", v, 32'h0000_0200);
        check_irqs("R7", 28'h200);
        pins_in[9] = 1'b0;
        reg_write(4'h8, 32'h0FFF_FFFF);
        settle(4);

        // R11: latency of exactly three rising edges
        reg_write(4'h0, 32'h0000_0020);
        pins_in[5] = 1'b1;
        reg_addr = 4'h8;
        @(posedge clk); @(posedge clk); @(negedge clk);
        reg_read(4'h8, v); check("R11 not yet after two edges", v, 32'h0);
        @(posedge clk); @(negedge clk);
        reg_read(4'h8, v); check("R11 set after third edge", v, 32'h0000_0020);

        // R6: transition and clear of the same bit in one cycle
        reg_write(4'h0, 32'h0000_0008);
        reg_write(4'h4, 32'h0000_0008);
        reg_write(4'h8, 32'h0FFF_FFFF);
        pins_in[3] = 1'b1;
        settle(4);
        reg_read(4'h8, v); check("R6 setup", v, 32'h0000_0028 & 32'h0000_0008);
        @(negedge clk);
        pins_in[3] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h0000_0008;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        reg_read(4'h8, v); check("R6 edge wins over clear", v, 32'h0000_0008);
        check_irqs("R6 R8", 28'h008);

        // R1: reset again with events pending
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_read(4'h8, v); check("R1 events after reset", v, 32'h0);
        reg_read(4'h0, v); check("R1 rise after reset", v, 32'h0);
        check_irqs("R1 after reset", 28'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule